// File: doc/BRIEF.md
# Multi-block spare allocation analyzer

This block works out how to repair a memory built from two blocks that share their spare lines. There are two kinds of spare. A global row spare replaces a given row address in every block at once. A common column spare is taken from a shared pool and is bound to one column of one chosen block. During memory test, failing cells are streamed in one per cycle as {block, row, column} on a valid/ready handshake. A separate end-of-list strobe closes the list.

Inside the block there is one sub-analyzer for every distinct order in which the spares can be consumed. With the default of two global rows and four common columns that gives C(6,2) = 15 sub-analyzers. Every fault is broadcast to all of them in the same cycle. A sub-analyzer skips a fault that one of its recorded spares already covers. An uncovered fault makes it claim the next spare in its order. When the list closes, the lowest-indexed sub-analyzer that covered every fault is selected, and its spare assignments are presented together with a success flag and a done flag.

Top module: `spr_alloc_top`

## Requirements
- R1: There are C(NG+NC, NG) sub-analyzers. Sub-analyzer k uses the k-th S-bit mask (S = NG+NC) that has exactly NG bits set, counting masks in ascending numeric order. Bit i = 1 means the i-th spare it consumes is a global row; bit i = 0 means a common column. With the defaults, index 0 has mask 6'b000011 and index 14 has mask 6'b110000.
- R2: A recorded global row spare covers every later fault on that row address, whatever the fault's block.
- R3: A recorded common column spare covers only later faults that have both the same block and the same column.
- R4: A covered fault, including an exact repeat of an earlier fault, consumes no spare.
- R5: If a sub-analyzer gets an uncovered fault after all S of its spares are used, it fails. The failure is sticky, and the sub-analyzer takes no further spares.
- R6: The lowest-indexed sub-analyzer that has not failed is selected, and its index appears on sel_idx_o. For each slot i, the outputs are: alloc_vld_o[i] (the slot is used); alloc_kind_o[i] (1 = global row, 0 = common column); alloc_blk_o[i] (block of the fault that claimed the slot); alloc_addr_o[i*ADDR_W +: ADDR_W] (the row address for a row slot, the column address for a column slot).
- R7: An end-of-list strobe is accepted on a clock edge while fault_rdy_o is high. From the next cycle fault_rdy_o is low. done_o rises on the second edge after acceptance and then stays high. Before done_o, repair_ok_o is 0.
- R8: An empty fault list ends with repair_ok_o = 1, sel_idx_o = 0 and all alloc_vld_o bits at 0.
- R9: If every sub-analyzer fails, repair_ok_o = 0, sel_idx_o = 0 and alloc_vld_o = 0.
- R10: After done_o, faults and strobes are not accepted and the results hold. An active-low reset clears all allocations, all fail flags and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts a new analysis |
| fault_vld_i | input | 1 | Fault address valid |
| fault_rdy_o | output | 1 | Analyzer can accept faults or the end strobe |
| fault_blk_i | input | BLK_W | Block of the fault |
| fault_row_i | input | ADDR_W | Row address of the fault |
| fault_col_i | input | ADDR_W | Column address of the fault |
| eol_i | input | 1 | End of fault list |
| done_o | output | 1 | Analysis finished; results valid |
| repair_ok_o | output | 1 | A sub-analyzer covered every fault |
| sel_idx_o | output | IDX_W | Index of the selected sub-analyzer |
| alloc_vld_o | output | S | Slot used |
| alloc_kind_o | output | S | Slot kind, 1 = global row |
| alloc_blk_o | output | S*BLK_W | Block of each slot |
| alloc_addr_o | output | S*ADDR_W | Row or column address of each slot |

## Verification
Each directed list isolates one piece of behaviour:
- Two blocks failing on the same row check that a single global row covers both blocks.
- Several faults in one column, in one block and then in the other, check that a column spare is bound to its block.
- A repeated fault checks that a covered fault consumes no spare.
- Seven faults on unrelated rows and columns exhaust every sub-analyzer.
- Column-heavy lists defeat the rows-first order, so a nonzero index must be selected.

Random lists drawn from a small address space produce many partial overlaps. On these, the bench model must match the selected index and every slot exactly. Faults offered after done_o check that the results hold.

// File: rtl/spr_alloc_pkg.sv
package spr_alloc_pkg;

  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
    return r;
  endfunction

  // k-th mask with ng ones among s bits, ascending numeric order
  function automatic logic [31:0] order_mask(input int s, input int ng, input int idx);
    int c;
    c = 0;
    for (int m = 0; m < (1 << s); m++) begin
      int p;
      p = 0;
      for (int b = 0; b < s; b++) p += (m >> b) & 1;
      if (p == ng) begin
        if (c == idx) return 32'(m);
        c++;
      end
    end
    return '0;
  endfunction

endpackage

// File: rtl/spr_alloc_sub.sv
module spr_alloc_sub #(
  parameter int          NG     = 2,
  parameter int          NC     = 4,
  parameter int          BLK_W  = 1,
  parameter int          ADDR_W = 4,
  parameter logic [31:0] ORDER  = 32'h3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_i,
  input  logic [BLK_W-1:0]          blk_i,
  input  logic [ADDR_W-1:0]         row_i,
  input  logic [ADDR_W-1:0]         col_i,
  output logic                      fail_o,
  output logic [NG+NC-1:0]          slot_vld_o,
  output logic [(NG+NC)*BLK_W-1:0]  slot_blk_o,
  output logic [(NG+NC)*ADDR_W-1:0] slot_addr_o
);
  localparam int S     = NG + NC;
  localparam int CNT_W = $clog2(S + 1);

  logic [S-1:0]      vld_q;
  logic [BLK_W-1:0]  blk_q  [S];
  logic [ADDR_W-1:0] addr_q [S];
  logic [CNT_W-1:0]  cnt_q;
  logic              fail_q;
  logic              hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < S; i++) begin
      if (vld_q[i]) begin
        if (ORDER[i]) begin
          if (addr_q[i] == row_i) hit = 1'b1;
        end else if (blk_q[i] == blk_i && addr_q[i] == col_i) begin
          hit = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
      for (int i = 0; i < S; i++) begin
        blk_q[i]  <= '0;
        addr_q[i] <= '0;
      end
    end else if (take_i && !hit && !fail_q) begin
      if (cnt_q == CNT_W'(S)) begin
        fail_q <= 1'b1;
      end else begin
        for (int i = 0; i < S; i++) begin
          if (cnt_q == CNT_W'(i)) begin
            vld_q[i]  <= 1'b1;
            blk_q[i]  <= blk_i;
            addr_q[i] <= ORDER[i] ? row_i : col_i;
          end
        end
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fail_o     = fail_q;
  assign slot_vld_o = vld_q;

  for (genvar g = 0; g < S; g++) begin : g_out
    assign slot_blk_o[g*BLK_W +: BLK_W]    = blk_q[g];
    assign slot_addr_o[g*ADDR_W +: ADDR_W] = addr_q[g];
  end

endmodule

// File: rtl/spr_alloc_pick.sv
module spr_alloc_pick #(
  parameter int NSUB   = 15,
  parameter int S      = 6,
  parameter int BLK_W  = 1,
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 4
) (
  input  logic [NSUB-1:0]          fail_i,
  input  logic [NSUB*S-1:0]        vld_i,
  input  logic [NSUB*S-1:0]        kind_i,
  input  logic [NSUB*S*BLK_W-1:0]  blk_i,
  input  logic [NSUB*S*ADDR_W-1:0] addr_i,
  output logic                     ok_o,
  output logic [IDX_W-1:0]         idx_o,
  output logic [S-1:0]             vld_o,
  output logic [S-1:0]             kind_o,
  output logic [S*BLK_W-1:0]       blk_o,
  output logic [S*ADDR_W-1:0]      addr_o
);
  always_comb begin
    ok_o  = 1'b0;
    idx_o = '0;
    for (int k = NSUB - 1; k >= 0; k--) begin
      if (!fail_i[k]) begin
        ok_o  = 1'b1;
        idx_o = IDX_W'(k);
      end
    end
    if (ok_o) begin
      vld_o  = vld_i[idx_o*S +: S];
      kind_o = kind_i[idx_o*S +: S];
      blk_o  = blk_i[idx_o*S*BLK_W +: S*BLK_W];
      addr_o = addr_i[idx_o*S*ADDR_W +: S*ADDR_W];
    end else begin
      vld_o  = '0;
      kind_o = '0;
      blk_o  = '0;
      addr_o = '0;
    end
  end
endmodule

// File: rtl/spr_alloc_top.sv
module spr_alloc_top #(
  parameter int NG     = 2,
  parameter int NC     = 4,
  parameter int BLK_W  = 1,
  parameter int ADDR_W = 4,
  localparam int S     = NG + NC,
  localparam int NSUB  = spr_alloc_pkg::binom(S, NG),
  localparam int IDX_W = (NSUB > 1) ? $clog2(NSUB) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fault_vld_i,
  output logic                  fault_rdy_o,
  input  logic [BLK_W-1:0]      fault_blk_i,
  input  logic [ADDR_W-1:0]     fault_row_i,
  input  logic [ADDR_W-1:0]     fault_col_i,
  input  logic                  eol_i,
  output logic                  done_o,
  output logic                  repair_ok_o,
  output logic [IDX_W-1:0]      sel_idx_o,
  output logic [S-1:0]          alloc_vld_o,
  output logic [S-1:0]          alloc_kind_o,
  output logic [S*BLK_W-1:0]    alloc_blk_o,
  output logic [S*ADDR_W-1:0]   alloc_addr_o
);
  logic fin_q, done_q, take;

  logic [NSUB-1:0]          sub_fail;
  logic [NSUB*S-1:0]        sub_vld, sub_kind;
  logic [NSUB*S*BLK_W-1:0]  sub_blk;
  logic [NSUB*S*ADDR_W-1:0] sub_addr;

  logic                pk_ok;
  logic [IDX_W-1:0]    pk_idx;
  logic [S-1:0]        pk_vld, pk_kind;
  logic [S*BLK_W-1:0]  pk_blk;
  logic [S*ADDR_W-1:0] pk_addr;

  assign fault_rdy_o = !fin_q && !done_q;
  assign take        = fault_vld_i && fault_rdy_o;

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    localparam logic [31:0] ORD = spr_alloc_pkg::order_mask(S, NG, k);
    assign sub_kind[k*S +: S] = ORD[S-1:0];
    spr_alloc_sub #(
      .NG(NG), .NC(NC), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .ORDER(ORD)
    ) u_sub (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .take_i     (take),
      .blk_i      (fault_blk_i),
      .row_i      (fault_row_i),
      .col_i      (fault_col_i),
      .fail_o     (sub_fail[k]),
      .slot_vld_o (sub_vld[k*S +: S]),
      .slot_blk_o (sub_blk[k*S*BLK_W +: S*BLK_W]),
      .slot_addr_o(sub_addr[k*S*ADDR_W +: S*ADDR_W])
    );
  end

  spr_alloc_pick #(
    .NSUB(NSUB), .S(S), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_pick (
    .fail_i(sub_fail),
    .vld_i (sub_vld),
    .kind_i(sub_kind),
    .blk_i (sub_blk),
    .addr_i(sub_addr),
    .ok_o  (pk_ok),
    .idx_o (pk_idx),
    .vld_o (pk_vld),
    .kind_o(pk_kind),
    .blk_o (pk_blk),
    .addr_o(pk_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fin_q        <= 1'b0;
      done_q       <= 1'b0;
      repair_ok_o  <= 1'b0;
      sel_idx_o    <= '0;
      alloc_vld_o  <= '0;
      alloc_kind_o <= '0;
      alloc_blk_o  <= '0;
      alloc_addr_o <= '0;
    end else begin
      if (eol_i && fault_rdy_o) fin_q <= 1'b1;
      // last fault settles in the same edge as the strobe; results latch one edge later
      if (fin_q && !done_q) begin
        done_q       <= 1'b1;
        repair_ok_o  <= pk_ok;
        sel_idx_o    <= pk_idx;
        alloc_vld_o  <= pk_vld;
        alloc_kind_o <= pk_kind;
        alloc_blk_o  <= pk_blk;
        alloc_addr_o <= pk_addr;
      end
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/spr_alloc_chk.sv
module spr_alloc_chk #(
  parameter int NG     = 2,
  parameter int NC     = 4,
  parameter int BLK_W  = 1,
  parameter int ADDR_W = 4,
  parameter int NSUB   = 15,
  parameter int IDX_W  = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   eol_i,
  input logic                   fault_rdy_o,
  input logic                   done_o,
  input logic                   repair_ok_o,
  input logic [IDX_W-1:0]       sel_idx_o,
  input logic [NG+NC-1:0]       alloc_vld_o,
  input logic [NG+NC-1:0]       alloc_kind_o
);
  a_r7_done_after_eol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_i && fault_rdy_o) |=> (!done_o && !fault_rdy_o) ##1 done_o);

  a_r7_ok_only_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !repair_ok_o);

  a_r10_results_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o && $stable(repair_ok_o) && $stable(sel_idx_o) && $stable(alloc_vld_o));

  a_r10_no_ready_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fault_rdy_o);

  a_r9_fail_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !repair_ok_o) |-> (alloc_vld_o == '0 && sel_idx_o == '0));

  a_r1_spare_budget: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(alloc_vld_o & alloc_kind_o) <= NG &&
                $countones(alloc_vld_o & ~alloc_kind_o) <= NC));

  a_r6_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(sel_idx_o) < NSUB));
endmodule

bind spr_alloc_top spr_alloc_chk #(
  .NG(NG), .NC(NC), .BLK_W(BLK_W), .ADDR_W(ADDR_W), .NSUB(NSUB), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .eol_i       (eol_i),
  .fault_rdy_o (fault_rdy_o),
  .done_o      (done_o),
  .repair_ok_o (repair_ok_o),
  .sel_idx_o   (sel_idx_o),
  .alloc_vld_o (alloc_vld_o),
  .alloc_kind_o(alloc_kind_o)
);

// File: tb/spr_alloc_top_tb.sv
module spr_alloc_top_tb;
  localparam int S = 6, NSUB = 15, BLK_W = 1, ADDR_W = 4, IDX_W = 4, MAXF = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fault_vld_i = 1'b0, eol_i = 1'b0, fault_rdy_o, done_o, repair_ok_o;
  logic [BLK_W-1:0] fault_blk_i = '0;
  logic [ADDR_W-1:0] fault_row_i = '0, fault_col_i = '0;
  logic [IDX_W-1:0] sel_idx_o;
  logic [S-1:0] alloc_vld_o, alloc_kind_o;
  logic [S*BLK_W-1:0] alloc_blk_o;
  logic [S*ADDR_W-1:0] alloc_addr_o;

  always #2 clk = ~clk;

  spr_alloc_top u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .fault_vld_i(fault_vld_i), .fault_rdy_o(fault_rdy_o),
    .fault_blk_i(fault_blk_i), .fault_row_i(fault_row_i), .fault_col_i(fault_col_i),
    .eol_i(eol_i), .done_o(done_o), .repair_ok_o(repair_ok_o), .sel_idx_o(sel_idx_o),
    .alloc_vld_o(alloc_vld_o), .alloc_kind_o(alloc_kind_o),
    .alloc_blk_o(alloc_blk_o), .alloc_addr_o(alloc_addr_o)
  );

  int n_chk = 0, n_bad = 0;
  int nf;
  logic [BLK_W-1:0]  fb [MAXF];
  logic [ADDR_W-1:0] fr [MAXF];
  logic [ADDR_W-1:0] fc [MAXF];

  logic               e_ok;
  logic [IDX_W-1:0]   e_idx;
  logic [S-1:0]       e_vld, e_kind;
  logic [S*BLK_W-1:0] e_blk;
  logic [S*ADDR_W-1:0] e_addr;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [S-1:0] combo(input int k);
    int c = 0;
    for (int m = 0; m < 64; m++) begin
      int p = 0;
      for (int b = 0; b < 6; b++) p += (m >> b) & 1;
      if (p == 2) begin
        if (c == k) return 6'(m);
        c++;
      end
    end
    return '0;
  endfunction

  task automatic model();
    e_ok = 1'b0; e_idx = '0; e_vld = '0; e_kind = '0; e_blk = '0; e_addr = '0;
    for (int k = 0; k < NSUB; k++) begin
      logic [S-1:0] msk, sv;
      logic [BLK_W-1:0] sb [S];
      logic [ADDR_W-1:0] sa [S];
      int cnt;
      bit bad;
      msk = combo(k); sv = '0; cnt = 0; bad = 0;
      for (int i = 0; i < S; i++) begin sb[i] = '0; sa[i] = '0; end
      for (int f = 0; f < nf; f++) begin
        bit cov = 0;
        for (int i = 0; i < S; i++)
          if (sv[i] && (msk[i] ? (sa[i] == fr[f]) : (sb[i] == fb[f] && sa[i] == fc[f]))) cov = 1;
        if (!cov && !bad) begin
          if (cnt == S) bad = 1;
          else begin
            sv[cnt] = 1'b1; sb[cnt] = fb[f]; sa[cnt] = msk[cnt] ? fr[f] : fc[f]; cnt++;
          end
        end
      end
      if (!bad && !e_ok) begin
        e_ok = 1'b1; e_idx = IDX_W'(k); e_vld = sv; e_kind = msk;
        for (int i = 0; i < S; i++) begin
          e_blk[i*BLK_W +: BLK_W] = sb[i];
          e_addr[i*ADDR_W +: ADDR_W] = sa[i];
        end
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
  endtask

  task automatic add(input int b, input int r, input int c);
    fb[nf] = BLK_W'(b); fr[nf] = ADDR_W'(r); fc[nf] = ADDR_W'(c); nf++;
  endtask

  task automatic run_list(input string tag);
    do_reset();
    for (int f = 0; f < nf; f++) begin
      @(negedge clk);
      fault_vld_i = 1'b1; fault_blk_i = fb[f]; fault_row_i = fr[f]; fault_col_i = fc[f];
    end
    @(negedge clk); fault_vld_i = 1'b0; eol_i = 1'b1;
    @(negedge clk); eol_i = 1'b0;
    check({tag, " R7 ready low after eol"}, 32'(fault_rdy_o), 32'd0);
    check({tag, " R7 done not yet"}, 32'(done_o), 32'd0);
    @(negedge clk);
    check({tag, " R7 done"}, 32'(done_o), 32'd1);
    model();
    check({tag, " R6 repair_ok"}, 32'(repair_ok_o), 32'(e_ok));
    check({tag, " R1 sel_idx"}, 32'(sel_idx_o), 32'(e_idx));
    check({tag, " R6 alloc_vld"}, 32'(alloc_vld_o), 32'(e_vld));
    check({tag, " R6 alloc_kind"}, 32'(alloc_kind_o & alloc_vld_o), 32'(e_kind & e_vld));
    check({tag, " R6 alloc_blk"}, 32'(alloc_blk_o), 32'(e_blk));
    check({tag, " R6 alloc_addr"}, 32'(alloc_addr_o), 32'(e_addr));
  endtask

  task automatic stray_after_done();
    @(negedge clk);
    fault_vld_i = 1'b1; fault_blk_i = 1'b1; fault_row_i = 4'hE; fault_col_i = 4'hD; eol_i = 1'b1;
    @(negedge clk); @(negedge clk);
    fault_vld_i = 1'b0; eol_i = 1'b0;
    check("R10 ready low in done", 32'(fault_rdy_o), 32'd0);
    check("R10 vld held", 32'(alloc_vld_o), 32'(e_vld));
    check("R10 addr held", 32'(alloc_addr_o), 32'(e_addr));
    check("R10 ok held", 32'(repair_ok_o), 32'(e_ok));
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7);
    @(negedge clk); @(negedge clk);
    check("R10 reset done", 32'(done_o), 32'd0);
    check("R10 reset ok", 32'(repair_ok_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R7 ready after reset", 32'(fault_rdy_o), 32'd1);

    nf = 0; run_list("empty");
    check("R8 empty ok", 32'(repair_ok_o), 32'd1);
    check("R8 empty vld", 32'(alloc_vld_o), 32'd0);
    check("R8 empty idx", 32'(sel_idx_o), 32'd0);

    nf = 0; add(0, 3, 5); add(1, 3, 9); run_list("grow");
    check("R2 one row slot", 32'(alloc_vld_o), 32'h01);
    check("R2 row addr", 32'(alloc_addr_o[3:0]), 32'd3);
    stray_after_done();

    nf = 0; add(1, 1, 7); add(1, 2, 7); add(1, 3, 7); add(0, 4, 7); add(0, 5, 7);
    run_list("ccol");
    check("R3 four slots", 32'(alloc_vld_o), 32'h0F);
    check("R3 slot2 blk", 32'(alloc_blk_o[2]), 32'd1);
    check("R3 slot3 blk", 32'(alloc_blk_o[3]), 32'd0);
    check("R3 slot3 col", 32'(alloc_addr_o[15:12]), 32'd7);

    nf = 0; for (int i = 0; i < 5; i++) add(1, 6, 2); run_list("dup");
    check("R4 duplicate single slot", 32'(alloc_vld_o), 32'h01);

    nf = 0; for (int i = 1; i <= 7; i++) add(0, i, i); run_list("over");
    check("R5 all fail", 32'(repair_ok_o), 32'd0);
    check("R9 vld zero", 32'(alloc_vld_o), 32'd0);
    check("R9 idx zero", 32'(sel_idx_o), 32'd0);

    nf = 0;
    for (int g = 1; g <= 4; g++) for (int j = 0; j < 3; j++) add(0, (g - 1) * 3 + j + 1, g);
    add(0, 14, 8); add(1, 14, 9); add(0, 15, 10); add(1, 15, 11);
    run_list("late");
    check("R6 late ok", 32'(repair_ok_o), 32'd1);
    check("R6 nonzero index", 32'(sel_idx_o != 0), 32'd1);

    for (int t = 0; t < 40; t++) begin
      int n = 1 + int'($urandom_range(9));
      nf = 0;
      for (int i = 0; i < n; i++)
        add(int'($urandom_range(1)), int'($urandom_range(3)), int'($urandom_range(3)));
      run_list("rand");
      if (t % 8 == 0) stray_after_done();
    end

    do_reset();
    @(negedge clk);
    check("R10 reset clears done", 32'(done_o), 32'd0);
    check("R10 reset clears vld", 32'(alloc_vld_o), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule